// File: doc/BRIEF.md
# Four-Way Traffic Light Sequencer

This block is a timed phase controller for a crossing with four approaches. It drives two 8-bit lamp ports: one serves the North–South approaches and the other serves the East–West approaches. The controller serves one axis at a time. While one axis runs, the other axis shows stop.

For the active axis the sequence is fixed: straight-ahead go, then amber, then left-turn go, then amber again. After that the other axis runs the same four steps, and the loop starts over. Green phases last a long dwell and amber phases last a short dwell. Both dwells are counted in ticks of a free-running enable input (`tick_en`). The period of that enable therefore sets how fast the whole cycle runs.

After reset, both ports show stop for one short dwell, and then the North–South axis starts.

Top module: `traffic_sequencer`

## Requirements
- R1: While `rst` is high, both lamp ports show the stop code 0x11.
- R2: After `rst` falls, both ports keep showing 0x11 for exactly SHORT_TICKS ticks, and then the North–South port moves to 0x44.
- R3: Only four lamp codes ever appear on either port: 0x44 for straight-ahead go, 0x22 for amber, 0x99 for left-turn go and 0x11 for stop.
- R4: The North–South port shows these codes in order while the East–West port shows 0x11: 0x44 for LONG_TICKS ticks, 0x22 for SHORT_TICKS ticks, 0x99 for LONG_TICKS ticks, then 0x22 for SHORT_TICKS ticks.
- R5: After the second North–South amber, the North–South port shows 0x11. The East–West port then runs the same four-step pattern with the same dwells. After the second East–West amber, the North–South port shows 0x44 again and the loop repeats.
- R6: Only cycles with `tick_en` high count toward a dwell. While `tick_en` is held low, both ports keep their values.
- R7: The two ports never show a go code (0x44 or 0x99) at the same time.
- R8: A port can change value only in the cycle after one in which `tick_en` was high and `rst` was low.
- R9: A reset asserted in the middle of the cycle clears the dwell count. After release, the full R2 all-stop phase runs before North–South go.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Time-base enable; each high cycle is one dwell tick |
| ns_lamps | output | 8 | Lamp code for the North–South approaches |
| ew_lamps | output | 8 | Lamp code for the East–West approaches |

## Verification
A wrong phase register shows up on the lamp ports at the clock edge where it goes wrong. It appears as a code out of order, an illegal code, or two conflicting go codes. A wrong dwell count is less visible: it shows only when the current phase ends early or late, so it can take up to LONG_TICKS ticks to appear. For this reason the bench counts the ticks that each displayed port pair stays on. It compares every pair and its duration against an expected queue, so any dwell error is reported at the first change of the ports that follows it.

// File: rtl/tl_pkg.sv
package tl_pkg;

    localparam logic [7:0] LAMP_GO    = 8'h44;
    localparam logic [7:0] LAMP_AMBER = 8'h22;
    localparam logic [7:0] LAMP_LEFT  = 8'h99;
    localparam logic [7:0] LAMP_STOP  = 8'h11;

    typedef enum logic [3:0] {
        PH_ALLSTOP = 4'd0,
        PH_NS_GO   = 4'd1,
        PH_NS_AMB1 = 4'd2,
        PH_NS_LEFT = 4'd3,
        PH_NS_AMB2 = 4'd4,
        PH_EW_GO   = 4'd5,
        PH_EW_AMB1 = 4'd6,
        PH_EW_LEFT = 4'd7,
        PH_EW_AMB2 = 4'd8
    } phase_e;

    typedef enum logic {
        AXIS_NS = 1'b0,
        AXIS_EW = 1'b1
    } axis_e;

    typedef enum logic [1:0] {
        STEP_GO   = 2'd0,
        STEP_AMB1 = 2'd1,
        STEP_LEFT = 2'd2,
        STEP_AMB2 = 2'd3
    } step_e;

    typedef struct packed {
        logic  active;
        axis_e axis;
        step_e step;
    } phase_info_t;

    function automatic phase_info_t phase_info(input phase_e ph);
        phase_info_t r;
        r.active = 1'b1;
        r.axis   = AXIS_NS;
        r.step   = STEP_GO;
        case (ph)
            PH_NS_GO:   r.step = STEP_GO;
            PH_NS_AMB1: r.step = STEP_AMB1;
            PH_NS_LEFT: r.step = STEP_LEFT;
            PH_NS_AMB2: r.step = STEP_AMB2;
            PH_EW_GO:   begin r.axis = AXIS_EW; r.step = STEP_GO;   end
            PH_EW_AMB1: begin r.axis = AXIS_EW; r.step = STEP_AMB1; end
            PH_EW_LEFT: begin r.axis = AXIS_EW; r.step = STEP_LEFT; end
            PH_EW_AMB2: begin r.axis = AXIS_EW; r.step = STEP_AMB2; end
            default:    r.active = 1'b0;
        endcase
        return r;
    endfunction

    function automatic phase_e phase_next(input phase_e ph);
        case (ph)
            PH_ALLSTOP: return PH_NS_GO;
            PH_NS_GO:   return PH_NS_AMB1;
            PH_NS_AMB1: return PH_NS_LEFT;
            PH_NS_LEFT: return PH_NS_AMB2;
            PH_NS_AMB2: return PH_EW_GO;
            PH_EW_GO:   return PH_EW_AMB1;
            PH_EW_AMB1: return PH_EW_LEFT;
            PH_EW_LEFT: return PH_EW_AMB2;
            PH_EW_AMB2: return PH_NS_GO;
            default:    return PH_ALLSTOP;
        endcase
    endfunction

    function automatic logic phase_is_long(input phase_e ph);
        phase_info_t i;
        i = phase_info(ph);
        return i.active && (i.step == STEP_GO || i.step == STEP_LEFT);
    endfunction

    function automatic logic [7:0] step_code(input step_e s);
        case (s)
            STEP_GO:   return LAMP_GO;
            STEP_LEFT: return LAMP_LEFT;
            default:   return LAMP_AMBER;
        endcase
    endfunction

    function automatic logic is_go_code(input logic [7:0] c);
        return (c == LAMP_GO) || (c == LAMP_LEFT);
    endfunction

endpackage

// File: rtl/tl_dwell_timer.sv
module tl_dwell_timer #(
    parameter int LONG_TICKS  = 10,
    parameter int SHORT_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic long_sel,
    output logic expire
);
    localparam int MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int CNT_W     = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_TICKS - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_TICKS - 1);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] last;

    assign last   = long_sel ? LONG_LAST : SHORT_LAST;
    assign expire = tick_en && (count_q == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (expire) begin
            count_q <= '0;
        end else if (tick_en) begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/tl_phase_fsm.sv
module tl_phase_fsm
    import tl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   advance,
    output phase_e phase,
    output logic   long_sel
);
    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ALLSTOP;
        end else if (advance) begin
            phase_q <= phase_next(phase_q);
        end
    end

    assign phase    = phase_q;
    assign long_sel = phase_is_long(phase_q);
endmodule

// File: rtl/tl_lamp_port.sv
module tl_lamp_port
    import tl_pkg::*;
#(
    parameter bit AXIS_SEL = 1'b0
) (
    input  phase_e     phase,
    output logic [7:0] lamps
);
    phase_info_t info;

    always_comb begin
        info = phase_info(phase);
        if (info.active && (info.axis == axis_e'(AXIS_SEL))) begin
            lamps = step_code(info.step);
        end else begin
            lamps = LAMP_STOP;
        end
    end
endmodule

// File: rtl/traffic_sequencer.sv
module traffic_sequencer
    import tl_pkg::*;
#(
    parameter int LONG_TICKS  = 10,
    parameter int SHORT_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    output logic [7:0] ns_lamps,
    output logic [7:0] ew_lamps
);
    localparam int N_PORTS = 2;

    logic       expire;
    logic       long_sel;
    phase_e     phase;
    logic [7:0] port_code [N_PORTS];

    tl_dwell_timer #(
        .LONG_TICKS (LONG_TICKS),
        .SHORT_TICKS(SHORT_TICKS)
    ) i_timer (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .long_sel(long_sel),
        .expire  (expire)
    );

    tl_phase_fsm i_fsm (
        .clk     (clk),
        .rst     (rst),
        .advance (expire),
        .phase   (phase),
        .long_sel(long_sel)
    );

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        tl_lamp_port #(.AXIS_SEL(p[0])) i_port (
            .phase(phase),
            .lamps(port_code[p])
        );
    end

    assign ns_lamps = port_code[0];
    assign ew_lamps = port_code[1];
endmodule

// File: rtl/tl_sequencer_chk.sv
module tl_sequencer_chk
    import tl_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick_en,
    input logic [7:0] ns_lamps,
    input logic [7:0] ew_lamps
);
    // R7
    no_dual_go_chk: assert property (@(posedge clk) disable iff (rst)
        !(is_go_code(ns_lamps) && is_go_code(ew_lamps)));

    // R3
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        ((ns_lamps == LAMP_GO) || (ns_lamps == LAMP_AMBER) || (ns_lamps == LAMP_LEFT) || (ns_lamps == LAMP_STOP)) &&
        ((ew_lamps == LAMP_GO) || (ew_lamps == LAMP_AMBER) || (ew_lamps == LAMP_LEFT) || (ew_lamps == LAMP_STOP)));

    // R8
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(tick_en) && !$past(rst)) |-> ($stable(ns_lamps) && $stable(ew_lamps)));

    // R5
    cross_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (ns_lamps != LAMP_STOP) |-> (ew_lamps == LAMP_STOP));

    // R4
    ns_starts_go_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ns_lamps) == LAMP_STOP && ns_lamps != LAMP_STOP) |-> (ns_lamps == LAMP_GO));

    // R1
    reset_stop_chk: assert property (@(posedge clk)
        $past(rst) |-> (ns_lamps == LAMP_STOP && ew_lamps == LAMP_STOP));
endmodule

bind traffic_sequencer tl_sequencer_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .ns_lamps(ns_lamps),
    .ew_lamps(ew_lamps)
);

// File: tb/test_traffic_sequencer.sv
module test_traffic_sequencer;
    localparam int LT = 10;
    localparam int ST = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [7:0] ns_lamps;
    logic [7:0] ew_lamps;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit mon_on = 1'b0;

    int    q_ns[$];
    int    q_ew[$];
    int    q_tk[$];
    string q_tag[$];

    logic [7:0] cur_ns, cur_ew;
    int run_ticks;
    int e_ns, e_ew, e_tk;
    string e_tag;

    always #4 clk = ~clk;

    traffic_sequencer #(.LONG_TICKS(LT), .SHORT_TICKS(ST)) i_traffic_sequencer (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .ns_lamps(ns_lamps),
        .ew_lamps(ew_lamps)
    );

    task automatic push(input int ns, input int ew, input int tk, input string tag);
        q_ns.push_back(ns);
        q_ew.push_back(ew);
        q_tk.push_back(tk);
        q_tag.push_back(tag);
    endtask

    task automatic push_cycle();
        push('h44, 'h11, LT, "R4");
        push('h22, 'h11, ST, "R4");
        push('h99, 'h11, LT, "R4");
        push('h22, 'h11, ST, "R4");
        push('h11, 'h44, LT, "R5");
        push('h11, 'h22, ST, "R5");
        push('h11, 'h99, LT, "R5");
        push('h11, 'h22, ST, "R5");
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Monitor: pops one expected item each time the displayed pair changes
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            if (ns_lamps !== cur_ns || ew_lamps !== cur_ew) begin
                if (q_ns.size() > 0) begin
                    e_ns  = q_ns.pop_front();
                    e_ew  = q_ew.pop_front();
                    e_tk  = q_tk.pop_front();
                    e_tag = q_tag.pop_front();
                    checks++;
                    if (int'(cur_ns) != e_ns || int'(cur_ew) != e_ew || run_ticks != e_tk) begin
                        fails++;
                        $display("FAIL %s actual ns=%h ew=%h ticks=%0d expected ns=%h ew=%h ticks=%0d",
                                 e_tag, cur_ns, cur_ew, run_ticks, e_ns, e_ew, e_tk);
                    end
                end
                cur_ns = ns_lamps;
                cur_ew = ew_lamps;
                run_ticks = 0;
            end
            if (tick_en) run_ticks++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    task automatic drive_ticks(input int mode, input int cycles);
        logic [7:0] lfsr;
        lfsr = 8'h5a;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            #1;
            case (mode)
                0: tick_en = 1'b1;
                1: tick_en = (i % 3 == 0);
                default: begin
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                    tick_en = lfsr[0];
                end
            endcase
        end
    endtask

    task automatic run_until_empty();
        for (int i = 0; i < 5000 && q_ns.size() > 0; i++) begin
            @(posedge clk);
            #1;
            tick_en = 1'b1;
        end
        @(posedge clk);
        #1;
        tick_en = 1'b0;
        check("R5 queue drained", q_ns.size(), 0);
    endtask

    task automatic arm_monitor();
        cur_ns = 8'h11;
        cur_ew = 8'h11;
        run_ticks = 0;
        mon_on = 1'b1;
    endtask

    initial begin
        logic [7:0] hold_ns, hold_ew;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 ns", ns_lamps, 'h11);
        check("R1 ew", ew_lamps, 'h11);

        // R2 all-stop dwell, then R3/R4/R5 cycles
        push('h11, 'h11, ST, "R2");
        push_cycle();
        push_cycle();
        push_cycle();
        arm_monitor();
        @(posedge clk);
        #1;
        rst = 1'b0;

        drive_ticks(0, 60);
        drive_ticks(1, 150);

        // R6 stall: no ticks, ports must hold
        @(posedge clk);
        #1;
        tick_en = 1'b0;
        @(negedge clk);
        hold_ns = ns_lamps;
        hold_ew = ew_lamps;
        repeat (40) @(posedge clk);
        @(negedge clk);
        check("R6 ns hold", ns_lamps, hold_ns);
        check("R6 ew hold", ew_lamps, hold_ew);

        drive_ticks(2, 60);
        run_until_empty();

        // R9 mid-cycle reset clears the timer
        drive_ticks(0, 13);
        mon_on = 1'b0;
        q_ns.delete();
        q_ew.delete();
        q_tk.delete();
        q_tag.delete();
        @(posedge clk);
        #1;
        rst = 1'b1;
        tick_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9 ns", ns_lamps, 'h11);
        check("R9 ew", ew_lamps, 'h11);
        push('h11, 'h11, ST, "R9");
        push('h44, 'h11, LT, "R9");
        push('h22, 'h11, ST, "R9");
        arm_monitor();
        @(posedge clk);
        #1;
        rst = 1'b0;
        drive_ticks(1, 30);
        run_until_empty();

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule